// File: doc/BRIEF.md
# Per-Port Fault Event Latch

This block holds the sticky fault status of a four-port power controller. Each port has two event flags: one for a disconnect, and one for an overcurrent that lasted too long. A one-cycle pulse from the port's disconnect detector sets the disconnect flag. The overcurrent flag is set by a per-port overload timer. That timer counts consecutive cycles of the port's overload level and resets to zero as soon as the level drops. While any flag is set, an active-high interrupt request is raised.

Software reads the flags through a small read port that takes a strobe and an address, and it has two addresses to choose from. One returns the flags and leaves them untouched. The other returns the same flags and then clears all of them.

Each port's overload timeout depends on its automatic cutoff setting. With cutoff enabled, the timeout is the overload window, and the port receives a one-cycle trip request when the flag sets. With cutoff disabled, the timeout is half the current-limit window, no trip request is issued, and a clearing read also restarts that port's overload count. While a port's off input is high, both of that port's flags are held at zero.

Top module: `port_fault_latch`

## Requirements
- R1: During and after synchronous reset, every flag is 0, and `rd_data`, `irq` and `ovc_trip` are 0.
- R2: Bit layout of the 8-bit flag word: bit 4+p is the disconnect flag of port index p (p = 0..3, index 0 is port 1), and bit p is its overcurrent flag. A `disc_evt[p]` pulse sets bit 4+p at the next clock edge.
- R3: A read strobe with address 0x06 loads the current flag word into `rd_data` at the next edge and leaves the flags unchanged.
- R4: A read strobe with address 0x07 loads the flag word as it stood before the read, and every flag is 0 after that edge.
- R5: An event that arrives in the same cycle as a 0x07 read still sets its flag.
- R6: While `port_off[p]` is high, bits 4+p and p stay 0, even if an event arrives for that port.
- R7: `irq` is high in exactly the cycles in which at least one flag is set. It changes at the same edge as the flags.
- R8: With `cut_en[p]` high, the overcurrent flag p sets at the OVLD_CYC-th consecutive edge with `ovld[p]` high, and `ovc_trip[p]` pulses for one cycle at that edge. A low cycle on `ovld[p]` restarts the count, and the flag sets only once in each overload episode.
- R9: With `cut_en[p]` low, the overcurrent flag p sets at the (LIM_CYC/2)-th consecutive overload edge, and `ovc_trip[p]` stays 0.
- R10: A 0x07 read restarts the overload count of every port whose `cut_en` is low. It leaves the count of ports with `cut_en` high unchanged.
- R11: A read strobe at any other address returns 0 in `rd_data` and changes no flag.
- R12: Once set, a flag stays set until a 0x07 read or the port's off input clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, high while any flag is set |
| disc_evt | input | 4 | Per-port disconnect event pulses |
| ovld | input | 4 | Per-port overload level |
| cut_en | input | 4 | Per-port automatic cutoff enable |
| port_off | input | 4 | Per-port off level; holds that port's flags at zero |
| ovc_trip | output | 4 | Per-port one-cycle cutoff request on overcurrent timeout |

## Verification
Two things can land on the same clock edge: a clearing read and the arrival of a new event, and also a clearing read and a running overload count. To provoke the first, a disconnect pulse is driven together with a 0x07 read. The read must return the old word, and the new bit must remain visible on a later non-destructive read. To provoke the second, a 0x07 read is issued partway through an overload episode, once with cutoff enabled and once with it disabled. The bench counts the edges until `irq` rises and compares that count with the undisturbed timeout in one case and with the restarted timeout in the other. A behavioural model in the bench checks every cycle as well.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_PEEK   = 2'd1,
    RD_CLEAR  = 2'd2,
    RD_OTHER  = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/pfl_ovc_timer.sv
module pfl_ovc_timer #(
  parameter int OVLD_CYC = 2000,
  parameter int LIM_CYC  = 3000,
  parameter int CNT_W    = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic ovld_i,
  input  logic cut_en_i,
  input  logic clr_i,
  output logic fire_o,
  output logic trip_o
);
  localparam int HALF_CYC = LIM_CYC / 2;
  localparam logic [CNT_W-1:0] OVLD_L = CNT_W'(OVLD_CYC);
  localparam logic [CNT_W-1:0] HALF_L = CNT_W'(HALF_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             trip_q;

  always_comb begin
    lim    = cut_en_i ? OVLD_L : HALF_L;
    fire_o = ovld_i && (cnt_q == lim - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      trip_q <= fire_o && cut_en_i;
      if (!ovld_i)
        cnt_q <= '0;
      else if (clr_i && !cut_en_i)
        cnt_q <= '0;
      else if (cnt_q < lim)
        cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign trip_o = trip_q;

  // R8
  cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !ovld_i |=> (cnt_q == '0));

  // R10
  clr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !cut_en_i) |=> (cnt_q == '0));

  // R9
  no_trip_chk: assert property (@(posedge clk) disable iff (rst)
    trip_o |-> $past(cut_en_i));
endmodule

// File: rtl/pfl_flag_bank.sv
module pfl_flag_bank #(
  parameter int NUM_PORTS = 4,
  localparam int DATA_W   = 2 * NUM_PORTS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] disc_i,
  input  logic [NUM_PORTS-1:0] ovc_i,
  input  logic [NUM_PORTS-1:0] off_i,
  input  logic                 clr_i,
  output logic [DATA_W-1:0]    flags_o,
  output logic                 irq_o
);
  logic [DATA_W-1:0] flags_q;
  logic [DATA_W-1:0] flags_d;
  logic              irq_q;

  always_comb begin
    flags_d = clr_i ? '0 : flags_q;
    flags_d = flags_d | {disc_i, ovc_i};
    flags_d = flags_d & ~{off_i, off_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= |flags_d;
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;

  // R6
  off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|off_i) |=> ((flags_q & {$past(off_i), $past(off_i)}) == '0));

  // R12
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && off_i == '0) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R5
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && off_i == '0) |=> (flags_q == $past({disc_i, ovc_i})));

  // R7
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|flags_q));
endmodule

// File: rtl/pfl_rd_port.sv
module pfl_rd_port
  import pfl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PEEK_ADDR  = 8'h06,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] flags_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              clr_o
);
  rd_kind_e          kind;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    if (!rd_en_i)                    kind = RD_IDLE;
    else if (rd_addr_i == PEEK_ADDR)  kind = RD_PEEK;
    else if (rd_addr_i == CLEAR_ADDR) kind = RD_CLEAR;
    else                              kind = RD_OTHER;
    clr_o = (kind == RD_CLEAR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (kind)
        RD_PEEK, RD_CLEAR: rd_q <= flags_i;
        RD_OTHER:          rd_q <= '0;
        default:           rd_q <= rd_q;
      endcase
    end
  end

  assign rd_data_o = rd_q;

  // R3 R4
  rd_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && (rd_addr_i == PEEK_ADDR || rd_addr_i == CLEAR_ADDR))
      |=> (rd_data_o == $past(flags_i)));

  // R11
  unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i != PEEK_ADDR && rd_addr_i != CLEAR_ADDR)
      |=> (rd_data_o == '0));
endmodule

// File: rtl/port_fault_latch.sv
module port_fault_latch #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  parameter int OVLD_CYC  = 2000,
  parameter int LIM_CYC   = 3000,
  parameter logic [ADDR_W-1:0] PEEK_ADDR  = 8'h06,
  parameter logic [ADDR_W-1:0] CLEAR_ADDR = 8'h07,
  localparam int DATA_W   = 2 * NUM_PORTS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 irq,
  input  logic [NUM_PORTS-1:0] disc_evt,
  input  logic [NUM_PORTS-1:0] ovld,
  input  logic [NUM_PORTS-1:0] cut_en,
  input  logic [NUM_PORTS-1:0] port_off,
  output logic [NUM_PORTS-1:0] ovc_trip
);
  localparam int HALF_CYC = LIM_CYC / 2;
  localparam int MAX_CYC  = (OVLD_CYC > HALF_CYC) ? OVLD_CYC : HALF_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic [NUM_PORTS-1:0] ovc_fire;
  logic [DATA_W-1:0]    flags;
  logic                 clr_rd;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pfl_ovc_timer #(
      .OVLD_CYC (OVLD_CYC),
      .LIM_CYC  (LIM_CYC),
      .CNT_W    (CNT_W)
    ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .ovld_i   (ovld[p]),
      .cut_en_i (cut_en[p]),
      .clr_i    (clr_rd),
      .fire_o   (ovc_fire[p]),
      .trip_o   (ovc_trip[p])
    );
  end

  pfl_flag_bank #(
    .NUM_PORTS (NUM_PORTS)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .disc_i  (disc_evt),
    .ovc_i   (ovc_fire),
    .off_i   (port_off),
    .clr_i   (clr_rd),
    .flags_o (flags),
    .irq_o   (irq)
  );

  pfl_rd_port #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PEEK_ADDR  (PEEK_ADDR),
    .CLEAR_ADDR (CLEAR_ADDR)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .flags_i   (flags),
    .rd_data_o (rd_data),
    .clr_o     (clr_rd)
  );

  // R1
  trip_reset_chk: assert property (@(posedge clk)
    rst |=> (ovc_trip == '0 && irq == 1'b0 && rd_data == '0));
endmodule

// File: tb/port_fault_latch_bench.sv
`timescale 1ns/1ps
module port_fault_latch_bench;
  localparam int NP   = 4;
  localparam int OVLD = 8;
  localparam int LIM  = 12;
  localparam int HALF = LIM / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       irq;
  logic [3:0] disc_evt = '0;
  logic [3:0] ovld = '0;
  logic [3:0] cut_en = 4'hF;
  logic [3:0] port_off = '0;
  logic [3:0] ovc_trip;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  port_fault_latch #(
    .NUM_PORTS (NP), .ADDR_W (8), .OVLD_CYC (OVLD), .LIM_CYC (LIM)
  ) u_port_fault_latch (
    .clk (clk), .rst (rst), .rd_en (rd_en), .rd_addr (rd_addr),
    .rd_data (rd_data), .irq (irq), .disc_evt (disc_evt), .ovld (ovld),
    .cut_en (cut_en), .port_off (port_off), .ovc_trip (ovc_trip)
  );

  // behavioural reference model
  logic [7:0] m_flags = '0;
  logic [7:0] m_rd = '0;
  logic       m_irq = 1'b0;
  logic [3:0] m_trip = '0;
  int         m_run [NP];
  bit         started = 0;

  always @(posedge clk) begin
    logic [3:0] ev_ovc;
    bit clr, peek;
    started = 1;
    if (rst) begin
      m_flags = '0; m_rd = '0; m_irq = 0; m_trip = '0;
      for (int p = 0; p < NP; p++) m_run[p] = 0;
    end else begin
      clr  = rd_en && rd_addr == 8'h07;
      peek = rd_en && rd_addr == 8'h06;
      ev_ovc = '0;
      for (int p = 0; p < NP; p++) begin
        int lim;
        lim = cut_en[p] ? OVLD : HALF;
        if (ovld[p]) begin
          if (m_run[p] < lim) begin
            m_run[p]++;
            if (m_run[p] == lim) ev_ovc[p] = 1'b1;
          end
        end else begin
          m_run[p] = 0;
        end
        if (clr && !cut_en[p]) m_run[p] = 0;
        m_trip[p] = ev_ovc[p] && cut_en[p];
      end
      if (rd_en) m_rd = (peek || clr) ? m_flags : 8'h00;
      if (clr) m_flags = '0;
      m_flags = m_flags | {disc_evt, ev_ovc};
      m_flags = m_flags & ~{port_off, port_off};
      m_irq = |m_flags;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("R3 R4 R11 rd_data per-cycle", int'(rd_data), int'(m_rd));
      chk("R7 irq per-cycle", int'(irq), int'(m_irq));
      chk("R8 R9 ovc_trip per-cycle", int'(ovc_trip), int'(m_trip));
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a);
    rd_en = 1'b1; rd_addr = a;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic run_ovld(input logic [3:0] mask, input int clr_at,
                          output int first, output int trips);
    first = 0; trips = 0;
    ovld = mask;
    for (int k = 1; k <= 30; k++) begin
      if (k == clr_at) begin rd_en = 1'b1; rd_addr = 8'h07; end
      tick();
      rd_en = 1'b0;
      if (irq && first == 0) first = k;
      if (|ovc_trip) trips++;
    end
    ovld = '0;
    tick();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int first, trips;
    repeat (3) tick();
    // R1 reset state
    chk("R1 rd_data after reset", int'(rd_data), 0);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 ovc_trip after reset", int'(ovc_trip), 0);
    rst = 1'b0;
    tick();

    // R2 R3 disconnect on port 2 -> bit 5, peek twice
    disc_evt = 4'b0010; tick(); disc_evt = '0;
    chk("R7 irq after event", int'(irq), 1);
    rd(8'h06); chk("R2 R3 peek word", int'(rd_data), 8'h20);
    rd(8'h06); chk("R3 peek leaves flags", int'(rd_data), 8'h20);

    // R4 clear-on-read
    rd(8'h07); chk("R4 clear read returns old", int'(rd_data), 8'h20);
    chk("R4 R7 irq released", int'(irq), 0);
    rd(8'h06); chk("R4 flags cleared", int'(rd_data), 8'h00);

    // R11 other address
    disc_evt = 4'b0001; tick(); disc_evt = '0;
    rd(8'h05); chk("R11 other address data", int'(rd_data), 8'h00);
    rd(8'h06); chk("R11 flags untouched", int'(rd_data), 8'h10);

    // R5 event in the clearing cycle
    disc_evt = 4'b1000; rd_en = 1'b1; rd_addr = 8'h07;
    tick();
    disc_evt = '0; rd_en = 1'b0;
    chk("R5 clear read returns pre-clear", int'(rd_data), 8'h10);
    rd(8'h06); chk("R5 event survives clear", int'(rd_data), 8'h80);

    // R6 port off
    port_off = 4'b1000; tick();
    chk("R6 irq after port off", int'(irq), 0);
    disc_evt = 4'b1000; tick(); disc_evt = '0;
    rd(8'h06); chk("R6 event blocked while off", int'(rd_data), 8'h00);
    port_off = '0; tick();

    // R8 cutoff enabled on port 1
    cut_en = 4'hF;
    run_ovld(4'b0001, 0, first, trips);
    chk("R8 timeout edges enabled", first, OVLD);
    chk("R8 single trip pulse", trips, 1);
    rd(8'h07); chk("R8 overcurrent bit 0", int'(rd_data), 8'h01);
    ovld = 4'b0001; repeat (OVLD - 3) tick();
    ovld = '0; tick();
    ovld = 4'b0001; repeat (OVLD - 3) tick();
    ovld = '0; tick();
    chk("R8 low cycle restarts count", int'(irq), 0);

    // R10 cutoff enabled: clear does not restart
    run_ovld(4'b0010, 4, first, trips);
    chk("R10 enabled count unaffected", first, OVLD);
    rd(8'h07); chk("R10 bit 1 set", int'(rd_data), 8'h02);

    // R9 cutoff disabled on port 3
    cut_en = 4'h0;
    run_ovld(4'b0100, 0, first, trips);
    chk("R9 timeout edges disabled", first, HALF);
    chk("R9 no trip when disabled", trips, 0);
    rd(8'h07); chk("R9 bit 2 set", int'(rd_data), 8'h04);

    // R10 cutoff disabled: clear restarts count
    run_ovld(4'b0100, 4, first, trips);
    chk("R10 disabled count restarted", first, 4 + HALF);
    chk("R10 no trip when disabled", trips, 0);

    // R12 sticky
    repeat (5) tick();
    rd(8'h06); chk("R12 flag holds", int'(rd_data), 8'h04);
    chk("R12 irq holds", int'(irq), 1);
    tick();
    finish_run();
  end
endmodule